// File: doc/BRIEF.md
# Lamp Ballast Startup Mode Sequencer

This block is the digital timing core of a fluorescent-lamp ballast controller. A saturating ramp accumulator (the timer code, 0.04 V per LSB) takes the place of an analog timing capacitor. It steps the inverter through warm-up, strike and steady running, and then into a latched halt. After startup the same accumulator becomes a feedback integrator. It is nudged up or down by a per-switching-cycle soft-switching verdict, and the oscillator's dead-time logic can read it back.

The sequencer takes three inputs: a supply-good level whose hysteresis has already been resolved, a slow tick strobe that sets the ramp pace, and an external pull-down request. It also takes a verdict strobe with a pass/fail bit. It outputs the current mode, the accumulator code and a frequency multiplier word in unsigned fixed point with 8 fraction bits, which a downstream oscillator scales against its running frequency. The startup phases happen only once per power cycle. A halt is possible only from the adaptive phase, and only a supply dropout clears it.

Top module: `ballast_seq`

## Requirements
- R1: While `supply_ok` is low, the block reports mode 0 (off), code 0 and multiplier 0 from the next clock edge on. The first edge with `supply_ok` high moves it to mode 1 (preheat) with code 0.
- R2: In mode 1, each edge with `tick` high adds 1 to the code, and other edges leave it unchanged. The multiplier is 409 (1.6 × 256, computed as 256 + (50 × 786 >> 8)).
- R3: When the code reaches 75 (3.0 V) or more, the mode becomes 2 (ignition) on the same edge. In mode 2 each tick adds 6.
- R4: In mode 2 the multiplier equals 256 + floor((125 − code) × 786 / 256), the fixed-point form of 1 + 0.3 × (5 V − Vcode).
- R5: When the code reaches 125 (5.0 V) or more, the mode becomes 3 (run). In mode 3 each tick adds 1, and the multiplier in modes 3 and 4 is 256.
- R6: When the code reaches 150 (6.0 V) or more, the mode becomes 4 (adaptive).
- R7: In mode 4, an edge with `zvs_valid` high adds 1 if `zvs_pass` is high and subtracts 1 otherwise. `zvs_valid` has no effect in any other mode.
- R8: The code saturates at 175 (7.0 V) and at 0 and never wraps.
- R9: Once mode 4 is reached, the code falling back into the 75 to 124 range does not bring back mode 2 or 3. The mode stays 4 and the multiplier stays 256.
- R10: In mode 4, an edge with both `ext_pull` and `tick` high subtracts 4, and this takes priority over a verdict on the same edge. `ext_pull` has no effect outside mode 4.
- R11: When the code drops below 65 (2.6 V) in mode 4, the mode becomes 5 (halt) on that edge. In mode 5 the code is frozen and the multiplier is 0 whatever `tick`, `ext_pull` or the verdict inputs do.
- R12: A low `supply_ok` clears every mode, including halt. When the supply returns, the full startup runs again from code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above lockout (hysteresis resolved upstream) |
| tick | input | 1 | Slow ramp-pace strobe |
| ext_pull | input | 1 | External request to drain the timer code |
| zvs_valid | input | 1 | One verdict per switching cycle |
| zvs_pass | input | 1 | Verdict value: 1 = soft switching achieved |
| mode_o | output | 3 | 0 off, 1 preheat, 2 ignition, 3 run, 4 adaptive, 5 halt |
| cph_o | output | 8 | Timer / integrator code, 0.04 V per LSB |
| freq_o | output | 10 | Frequency multiplier, 8 fraction bits |

## Verification
On every cycle the assertions check the code ceiling and the forced off state after a supply dropout. They also check that the code freezes in halt, that adaptive mode can only stay put or halt, and that the code holds still in preheat between ticks and in adaptive mode without a verdict or drain. The fixed multiplier in run and adaptive modes is checked the same way. Only the bench's scenarios show the exact thresholds where the modes change, the ignition multiplier curve and the saturation point. They also show that the startup latch survives a fall back into the ignition range, that a drain wins over a verdict on the same edge, and that a dropout restarts the whole sequence.

// File: rtl/ballast_pkg.sv
package ballast_pkg;
  typedef enum logic [2:0] {
    MODE_OFF     = 3'd0,
    MODE_PREHEAT = 3'd1,
    MODE_IGNITE  = 3'd2,
    MODE_RUN     = 3'd3,
    MODE_ADAPT   = 3'd4,
    MODE_HALT    = 3'd5
  } lamp_mode_e;
endpackage

// File: rtl/cph_ramp.sv
module cph_ramp #(
  parameter int CODE_W = 8,
  parameter int CEIL   = 175
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              up_i,
  input  logic [CODE_W-1:0] step_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] code_nxt_o
);
  localparam int SUM_W = CODE_W + 1;

  logic [CODE_W-1:0] code_q;
  logic [SUM_W-1:0]  sum;
  logic [CODE_W-1:0] up_val;
  logic [CODE_W-1:0] dn_val;

  always_comb begin
    sum    = {1'b0, code_q} + {1'b0, step_i};
    up_val = (sum > SUM_W'(CEIL)) ? CODE_W'(CEIL) : sum[CODE_W-1:0];
    dn_val = (code_q > step_i) ? (code_q - step_i) : '0;
    if (clr_i)     code_nxt_o = '0;
    else if (en_i) code_nxt_o = up_i ? up_val : dn_val;
    else           code_nxt_o = code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_nxt_o;
  end

  assign code_o = code_q;
endmodule

// File: rtl/freq_map.sv
module freq_map
  import ballast_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int MULT_W = 10,
  parameter int FRAC_W = 8,
  parameter int IGN_LO = 75,
  parameter int RUN_LO = 125,
  parameter int SLOPE  = 786
) (
  input  lamp_mode_e        mode_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [MULT_W-1:0] mult_o
);
  localparam int PW       = CODE_W + 12;
  localparam int UNITY    = 1 << FRAC_W;
  localparam int PRE_MULT = UNITY + (((RUN_LO - IGN_LO) * SLOPE) >> FRAC_W);

  logic [PW-1:0] gap;
  logic [PW-1:0] prod;

  always_comb begin
    gap  = (code_i < CODE_W'(RUN_LO)) ? (PW'(RUN_LO) - PW'(code_i)) : '0;
    prod = gap * PW'(SLOPE);
    case (mode_i)
      MODE_PREHEAT: mult_o = MULT_W'(PRE_MULT);
      MODE_IGNITE:  mult_o = MULT_W'(UNITY) + MULT_W'(prod >> FRAC_W);
      MODE_RUN,
      MODE_ADAPT:   mult_o = MULT_W'(UNITY);
      default:      mult_o = '0;
    endcase
  end
endmodule

// File: rtl/ballast_seq.sv
module ballast_seq
  import ballast_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int MULT_W    = 10,
  parameter int FRAC_W    = 8,
  parameter int PRE_STEP  = 1,
  parameter int IGN_STEP  = 6,
  parameter int ZVS_STEP  = 1,
  parameter int PULL_STEP = 4,
  parameter int IGN_LO    = 75,
  parameter int RUN_LO    = 125,
  parameter int ADAPT_LO  = 150,
  parameter int HALT_LO   = 65,
  parameter int CEIL      = 175,
  parameter int SLOPE     = 786
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              tick,
  input  logic              ext_pull,
  input  logic              zvs_valid,
  input  logic              zvs_pass,
  output logic [2:0]        mode_o,
  output logic [CODE_W-1:0] cph_o,
  output logic [MULT_W-1:0] freq_o
);
  lamp_mode_e        state_q, state_d;
  logic              clr, en, up;
  logic [CODE_W-1:0] step;
  logic [CODE_W-1:0] code_q, code_nxt;

  // next-state and ramp control
  always_comb begin
    state_d = state_q;
    clr     = 1'b0;
    en      = 1'b0;
    up      = 1'b1;
    step    = CODE_W'(PRE_STEP);
    if (!supply_ok) begin
      clr     = 1'b1;
      state_d = MODE_OFF;
    end else begin
      case (state_q)
        MODE_OFF: begin
          clr     = 1'b1;
          state_d = MODE_PREHEAT;
        end
        MODE_PREHEAT: begin
          en = tick;
          if (code_nxt >= CODE_W'(IGN_LO)) state_d = MODE_IGNITE;
        end
        MODE_IGNITE: begin
          en   = tick;
          step = CODE_W'(IGN_STEP);
          if (code_nxt >= CODE_W'(RUN_LO)) state_d = MODE_RUN;
        end
        MODE_RUN: begin
          en = tick;
          if (code_nxt >= CODE_W'(ADAPT_LO)) state_d = MODE_ADAPT;
        end
        MODE_ADAPT: begin
          if (ext_pull && tick) begin
            en   = 1'b1;
            up   = 1'b0;
            step = CODE_W'(PULL_STEP);
          end else if (zvs_valid) begin
            en   = 1'b1;
            up   = zvs_pass;
            step = CODE_W'(ZVS_STEP);
          end
          if (code_nxt < CODE_W'(HALT_LO)) state_d = MODE_HALT;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MODE_OFF;
    else        state_q <= state_d;
  end

  cph_ramp #(.CODE_W(CODE_W), .CEIL(CEIL)) u_ramp (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr),
    .en_i       (en),
    .up_i       (up),
    .step_i     (step),
    .code_o     (code_q),
    .code_nxt_o (code_nxt)
  );

  freq_map #(
    .CODE_W (CODE_W), .MULT_W (MULT_W), .FRAC_W (FRAC_W),
    .IGN_LO (IGN_LO), .RUN_LO (RUN_LO), .SLOPE  (SLOPE)
  ) u_freq (
    .mode_i (state_q),
    .code_i (code_q),
    .mult_o (freq_o)
  );

  assign mode_o = state_q;
  assign cph_o  = code_q;
endmodule

// File: rtl/ballast_seq_chk.sv
module ballast_seq_chk #(
  parameter int CODE_W = 8,
  parameter int MULT_W = 10,
  parameter int FRAC_W = 8,
  parameter int CEIL   = 175
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_ok,
  input logic              tick,
  input logic              ext_pull,
  input logic              zvs_valid,
  input logic [2:0]        mode_o,
  input logic [CODE_W-1:0] cph_o,
  input logic [MULT_W-1:0] freq_o
);
  a_r1_dropout_off: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (mode_o == 3'd0 && cph_o == '0 && freq_o == '0));

  a_r8_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    cph_o <= CODE_W'(CEIL));

  a_r11_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd5 && supply_ok) |=> (mode_o == 3'd5 && $stable(cph_o) && freq_o == '0));

  a_r9_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4 && supply_ok) |=> (mode_o == 3'd4 || mode_o == 3'd5));

  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd1 && supply_ok && !tick) |=> $stable(cph_o));

  a_r7_hold_without_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4 && supply_ok && !zvs_valid && !(ext_pull && tick)) |=> $stable(cph_o));

  a_r5_run_unity: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd3 || mode_o == 3'd4) |-> freq_o == MULT_W'(1 << FRAC_W));
endmodule

bind ballast_seq ballast_seq_chk #(
  .CODE_W (CODE_W), .MULT_W (MULT_W), .FRAC_W (FRAC_W), .CEIL (CEIL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .supply_ok (supply_ok),
  .tick      (tick),
  .ext_pull  (ext_pull),
  .zvs_valid (zvs_valid),
  .mode_o    (mode_o),
  .cph_o     (cph_o),
  .freq_o    (freq_o)
);

// File: tb/ballast_seq_bench.sv
module ballast_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b0, tick = 1'b0, ext_pull = 1'b0;
  logic       zvs_valid = 1'b0, zvs_pass = 1'b0;
  logic [2:0] mode_o;
  logic [7:0] cph_o;
  logic [9:0] freq_o;

  int n_tests = 0, n_fail = 0, cyc_cnt = 0;
  int m_mode = 0, m_code = 0;

  always #5 clk = ~clk;

  ballast_seq u_ballast_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .tick(tick),
    .ext_pull(ext_pull), .zvs_valid(zvs_valid), .zvs_pass(zvs_pass),
    .mode_o(mode_o), .cph_o(cph_o), .freq_o(freq_o)
  );

  function automatic int exp_freq(int md, int cd);
    case (md)
      1: return 409;
      2: return 256 + ((125 - cd) * 786) / 256;
      3, 4: return 256;
      default: return 0;
    endcase
  endfunction

  function automatic string mode_tag(int md);
    case (md)
      0: return "R1"; 1: return "R2"; 2: return "R4";
      3: return "R5"; 4: return "R7"; default: return "R11";
    endcase
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    int nc;
    nc = m_code;
    if (!rst_n) begin m_mode = 0; m_code = 0; end
    else if (!supply_ok) begin m_mode = 0; m_code = 0; end
    else begin
      case (m_mode)
        0: begin m_code = 0; m_mode = 1; end
        1: if (tick) begin nc = (m_code + 1 > 175) ? 175 : m_code + 1;
             m_code = nc; if (nc >= 75) m_mode = 2; end
        2: if (tick) begin nc = (m_code + 6 > 175) ? 175 : m_code + 6;
             m_code = nc; if (nc >= 125) m_mode = 3; end
        3: if (tick) begin nc = (m_code + 1 > 175) ? 175 : m_code + 1;
             m_code = nc; if (nc >= 150) m_mode = 4; end
        4: begin
             if (ext_pull && tick) nc = (m_code > 4) ? m_code - 4 : 0;
             else if (zvs_valid) begin
               if (zvs_pass) nc = (m_code + 1 > 175) ? 175 : m_code + 1;
               else          nc = (m_code > 1) ? m_code - 1 : 0;
             end
             m_code = nc;
             if (nc < 65) m_mode = 5;
           end
        default: ;
      endcase
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one cycle: compare with the model at the falling edge, then drive
  task automatic cyc(bit tk, bit zv, bit zp, bit ep);
    @(negedge clk);
    if (rst_n) begin
      check(mode_tag(m_mode), "model mode", int'(mode_o), m_mode);
      check(mode_tag(m_mode), "model code", int'(cph_o), m_code);
      check(mode_tag(m_mode), "model freq", int'(freq_o), exp_freq(m_mode, m_code));
    end
    tick = tk; zvs_valid = zv; zvs_pass = zp; ext_pull = ep;
  endtask

  task automatic ramp_to(int target);
    for (int i = 0; i < 4000 && m_mode != target; i++) cyc(i % 4 == 0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc_cnt);
      $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1);
    check("R1", "off mode", int'(mode_o), 0);
    check("R1", "off code", int'(cph_o), 0);
    check("R1", "off freq", int'(freq_o), 0);
    supply_ok = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    check("R1", "start in preheat", int'(mode_o), 1);
    check("R2", "preheat multiplier", int'(freq_o), 409);
    // verdicts without tick in preheat do nothing
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    check("R7", "verdict ignored in preheat", int'(cph_o), 0);
    ramp_to(2);
    check("R3", "ignition entry code", int'(cph_o), 75);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    check("R3", "ignition step", int'(cph_o), 81);
    check("R4", "ignition multiplier at 81", int'(freq_o), 391);
    ramp_to(3);
    check("R5", "run entry code", int'(cph_o), 129);
    check("R5", "run multiplier", int'(freq_o), 256);
    ramp_to(4);
    check("R6", "adaptive entry code", int'(cph_o), 150);
    check("R6", "adaptive mode", int'(mode_o), 4);
    for (int i = 0; i < 30; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    check("R8", "ceiling saturation", int'(cph_o), 175);
    for (int i = 0; i < 75; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    check("R7", "fail verdicts lower code", int'(cph_o), 100);
    check("R9", "no re-entry to ignition", int'(mode_o), 4);
    check("R9", "multiplier stays unity", int'(freq_o), 256);
    for (int i = 0; i < 36; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    check("R11", "halt mode", int'(mode_o), 5);
    check("R11", "halt code", int'(cph_o), 64);
    check("R11", "halt multiplier", int'(freq_o), 0);
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, i[0], 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    check("R11", "halt frozen code", int'(cph_o), 64);
    check("R11", "halt latched", int'(mode_o), 5);
    supply_ok = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    check("R12", "dropout clears halt", int'(mode_o), 0);
    check("R12", "dropout clears code", int'(cph_o), 0);
    supply_ok = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    check("R12", "restart in preheat", int'(mode_o), 1);
    check("R10", "pull ignored in preheat", int'(cph_o), 10);
    ramp_to(4);
    check("R12", "second adaptive entry", int'(cph_o), 150);
    cyc(1'b1, 1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    check("R10", "pull beats pass verdict", int'(cph_o), 146);
    for (int i = 0; i < 21; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    check("R10", "pull drives halt", int'(mode_o), 5);
    check("R10", "halt code after pull", int'(cph_o), 62);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule